// File: doc/BRIEF.md
# Counter-Driven Dimmable Pulse-Position Modulator

This block drives the on/off line of a visible-light LED driver so that one data bit and a brightness level are sent together. A symbol spans `N_T` cycles of the sample clock. Within each symbol the line is high for a number of samples equal to the dimming level. For a data bit of 0 that high pulse sits at the start of the symbol, and for a data bit of 1 it sits at the end. The average light output therefore follows the dimming level, while the position of the pulse carries the bit.

The waveform is built without any codeword storage. On each symbol-start strobe the block captures the data bit and the dimming level, clamped to `N_T`. It then derives a transition sample, which is the level itself for bit 0 and `N_T` minus the level for bit 1. A sample counter restarts at zero. While the counter is below the transition sample, the line shows the inverse of the bit. From that sample to the end of the symbol, the line shows the bit itself. A level of 0 keeps the line dark and a level of `N_T` keeps it lit, and in both cases no data is carried. The input side has no back-pressure: the block always accepts the bit and level present on the strobe cycle. The strobe is expected once every `N_T` sample clocks.

Top module: `vppm_mod`

## Requirements
- R1: While reset is asserted, and after reset until the first symbol-start strobe, `vppm_out` is 0. Reset is asynchronous and active low, and forces the line low at once.
- R2: For data bit 0 and level D with 0 < D < N_T, the line is 1 for samples 0 to D−1 of the symbol and 0 for samples D to N_T−1. Sample k is visible in the cycle after the k-th rising edge that follows the strobe edge. Example with N_T = 10 and D = 1: 1000000000. Example with D = 5: 1111100000.
- R3: For data bit 1 and level D with 0 < D < N_T, the line is 0 for samples 0 to N_T−D−1 and 1 for the last D samples. Example with N_T = 10 and D = 1: 0000000001. Example with D = 5: 0000011111.
- R4: A level of 0 holds the line at 0 for the whole symbol, whatever the data bit.
- R5: A level of N_T holds the line at 1 for the whole symbol, whatever the data bit.
- R6: Any level above N_T gives the same waveform as a level of N_T.
- R7: The data bit and level are sampled only on the strobe cycle. Changing either one during a symbol does not alter that symbol's waveform.
- R8: If no strobe arrives after the last sample of a symbol, the counter stays at N_T−1 and the line keeps the value of that last sample.
- R9: A strobe always restarts the symbol at sample 0 with the newly captured bit and level. This holds when it arrives exactly N_T cycles after the previous strobe and also when it arrives earlier, in the middle of a symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one cycle per sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_start | input | 1 | Symbol-start strobe, one cycle high per symbol |
| tx_bit | input | 1 | Data bit for the symbol, captured on the strobe |
| dim_level | input | $clog2(N_T+1) | Pulse width in samples, 0 to N_T; larger values are clamped; captured on the strobe |
| vppm_out | output | 1 | Modulated line to the LED driver |

## Verification
The two functions that share a cycle are the symbol restart and the end-of-symbol saturation. A strobe at the regular cadence lands on the same edge where the counter sits at its last sample and would otherwise hold. The table vectors are applied back to back with no idle cycle, and a strobe is also fired in the middle of a symbol. The judgment is that sample 0 of the new symbol appears on the very next cycle with the new bit and level, while the previous symbol's last sample is still shown correctly. In a separate case the strobe is withheld, and the line is judged to hold its last value.

// File: rtl/vppm_pkg.sv
package vppm_pkg;

  // Sample counter run state
  typedef enum logic {
    CNT_IDLE = 1'b0,
    CNT_RUN  = 1'b1
  } cnt_state_e;

endpackage

// File: rtl/vppm_sym_latch.sv
// Captures the data bit and the clamped dimming level on the symbol strobe
// and derives the transition sample for the symbol.
module vppm_sym_latch #(
  parameter int unsigned N_T   = 10,
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_start,
  input  logic             data_bit,
  input  logic [LVL_W-1:0] dim_level,
  output logic             bit_q,
  output logic [LVL_W-1:0] tp_q
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(N_T);

  logic [LVL_W-1:0] lvl_sat;
  logic [LVL_W-1:0] tp_next;

  // Clamp out-of-range levels to full brightness
  always_comb begin
    lvl_sat = (dim_level > FULL) ? FULL : dim_level;
  end

  // Bit 0: pulse leads, transition after lvl samples.
  // Bit 1: pulse trails, transition after FULL - lvl samples.
  always_comb begin
    if (data_bit) tp_next = FULL - lvl_sat;
    else          tp_next = lvl_sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      tp_q  <= '0;
    end else if (sym_start) begin
      bit_q <= data_bit;
      tp_q  <= tp_next;
    end
  end

  // R6
  tp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tp_q <= FULL);

  // R7
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_start |=> ($stable(tp_q) && $stable(bit_q)));

endmodule

// File: rtl/vppm_sample_ctr.sv
// Sample index within the symbol: restarts on the strobe, counts up and
// saturates on the last sample when the next strobe is late.
module vppm_sample_ctr
  import vppm_pkg::*;
#(
  parameter int unsigned N_T   = 10,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_start,
  output logic [IDX_W-1:0] idx,
  output logic             active
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_T - 1);

  cnt_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CNT_IDLE;
      idx     <= '0;
    end else if (sym_start) begin
      state_q <= CNT_RUN;
      idx     <= '0;
    end else if (state_q == CNT_RUN && idx != LAST) begin
      idx <= idx + 1'b1;
    end
  end

  assign active = (state_q == CNT_RUN);

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |=> (idx == '0 && active));

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sym_start && idx != LAST) |=> (idx == $past(idx) + 1'b1));

  // R8
  idx_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sym_start && idx == LAST) |=> (idx == LAST));

  // R1
  idle_until_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !sym_start) |=> !active);

endmodule

// File: rtl/vppm_out_sel.sv
// Compares the sample index with the transition sample and picks the
// data bit or its inverse.
module vppm_out_sel #(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned IDX_W = 4
) (
  input  logic             active,
  input  logic [IDX_W-1:0] idx,
  input  logic [LVL_W-1:0] tp_q,
  input  logic             bit_q,
  output logic             line
);

  logic before_tp;
  logic sel_val;

  always_comb begin
    before_tp = (LVL_W'(idx) < tp_q);
    sel_val   = before_tp ? ~bit_q : bit_q;
    line      = active & sel_val;
  end

endmodule

// File: rtl/vppm_mod.sv
// Top level: dimmable pulse-position modulator
module vppm_mod #(
  parameter  int unsigned N_T   = 10,
  localparam int unsigned LVL_W = $clog2(N_T + 1),
  localparam int unsigned IDX_W = (N_T > 2) ? $clog2(N_T) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_start,
  input  logic             tx_bit,
  input  logic [LVL_W-1:0] dim_level,
  output logic             vppm_out
);

  logic             bit_q;
  logic [LVL_W-1:0] tp_q;
  logic [IDX_W-1:0] idx;
  logic             active;

  vppm_sym_latch #(.N_T(N_T), .LVL_W(LVL_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_start (sym_start),
    .data_bit  (tx_bit),
    .dim_level (dim_level),
    .bit_q     (bit_q),
    .tp_q      (tp_q)
  );

  vppm_sample_ctr #(.N_T(N_T), .IDX_W(IDX_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_start (sym_start),
    .idx       (idx),
    .active    (active)
  );

  vppm_out_sel #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_sel (
    .active (active),
    .idx    (idx),
    .tp_q   (tp_q),
    .bit_q  (bit_q),
    .line   (vppm_out)
  );

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !vppm_out);

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sym_start && idx == IDX_W'(N_T - 1)) |=> $stable(vppm_out));

endmodule

// File: tb/vppm_mod_tb.sv
`timescale 1ns/1ps
module vppm_mod_tb;

  localparam int N_T   = 10;
  localparam int LVL_W = 4;
  localparam int NV    = 14;

  typedef struct packed {
    logic [3:0]     req;
    logic [3:0]     lvl;
    logic           b;
    logic [N_T-1:0] pat;   // MSB is sample 0
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd2, 4'd1,  1'b0, 10'b1000000000},  // R2 10% bit 0
    '{4'd3, 4'd1,  1'b1, 10'b0000000001},  // R3 10% bit 1
    '{4'd2, 4'd5,  1'b0, 10'b1111100000},  // R2 50% bit 0
    '{4'd3, 4'd5,  1'b1, 10'b0000011111},  // R3 50% bit 1
    '{4'd2, 4'd3,  1'b0, 10'b1110000000},  // R2
    '{4'd3, 4'd7,  1'b1, 10'b0001111111},  // R3
    '{4'd2, 4'd9,  1'b0, 10'b1111111110},  // R2
    '{4'd4, 4'd0,  1'b0, 10'b0000000000},  // R4
    '{4'd4, 4'd0,  1'b1, 10'b0000000000},  // R4
    '{4'd5, 4'd10, 1'b0, 10'b1111111111},  // R5
    '{4'd5, 4'd10, 1'b1, 10'b1111111111},  // R5
    '{4'd6, 4'd12, 1'b0, 10'b1111111111},  // R6
    '{4'd6, 4'd15, 1'b1, 10'b1111111111},  // R6
    '{4'd3, 4'd2,  1'b1, 10'b0000000011}   // R3
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sym_start = 1'b0;
  logic             tx_bit = 1'b0;
  logic [LVL_W-1:0] dim_level = '0;
  logic             vppm_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vppm_mod #(.N_T(N_T)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_start (sym_start),
    .tx_bit    (tx_bit),
    .dim_level (dim_level),
    .vppm_out  (vppm_out)
  );

  task automatic check(input logic exp, input int req, input int tag);
    n_chk++;
    if (vppm_out !== exp) begin
      n_fail++;
      $display("FAIL R%0d step %0d: actual %b expected %b", req, tag, vppm_out, exp);
    end
  endtask

  // Called at a negedge; drives the strobe, then checks nsamp samples.
  // Scrambles bit and level mid-symbol (R7). Returns at the negedge of the
  // last checked sample so the next strobe follows with no gap (R9).
  task automatic run_sym(input logic [3:0] lvl, input logic b,
                         input logic [N_T-1:0] pat, input int req,
                         input int nsamp);
    sym_start = 1'b1;
    dim_level = lvl;
    tx_bit    = b;
    @(negedge clk);
    sym_start = 1'b0;
    dim_level = ~lvl;
    tx_bit    = ~b;
    for (int k = 0; k < nsamp; k++) begin
      if (k != 0) @(negedge clk);
      check(pat[N_T-1-k], req, k);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: low in reset and idle after it
    repeat (3) begin @(negedge clk); check(1'b0, 1, 0); end
    rst_n = 1'b1;
    dim_level = 4'd10;
    tx_bit = 1'b0;
    repeat (5) begin @(negedge clk); check(1'b0, 1, 1); end

    // Table walk, back-to-back symbols (R2..R7, R9 at cadence)
    for (int v = 0; v < NV; v++)
      run_sym(VECS[v].lvl, VECS[v].b, VECS[v].pat, int'(VECS[v].req), N_T);

    // R8: no strobe after a symbol ending high, then one ending low
    run_sym(4'd3, 1'b1, 10'b0000000111, 3, N_T);
    repeat (6) begin @(negedge clk); check(1'b1, 8, 0); end
    @(negedge clk);
    run_sym(4'd3, 1'b0, 10'b1110000000, 2, N_T);
    repeat (6) begin @(negedge clk); check(1'b0, 8, 1); end
    @(negedge clk);

    // R9: early strobe in the middle of a symbol
    run_sym(4'd4, 1'b0, 10'b1111000000, 2, 6);
    @(negedge clk);
    run_sym(4'd6, 1'b1, 10'b0000111111, 9, N_T);
    run_sym(4'd8, 1'b0, 10'b1111111100, 9, 2);
    @(negedge clk);
    run_sym(4'd4, 1'b1, 10'b0000001111, 9, N_T);

    // R1: reset mid-symbol forces low at once and stays idle
    run_sym(4'd10, 1'b0, 10'b1111111111, 5, 3);
    #2 rst_n = 1'b0;
    #1 check(1'b0, 1, 2);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin @(negedge clk); check(1'b0, 1, 3); end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule